// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Steering

This block sits between a 16-bit core and two shared 8-bit external port groups. Each group time-shares address and data under the enable strobe E. While E is high, the upper port and the second port drive the middle and top address bytes. While E is low, they become data lanes. A third, dedicated port drives the lowest address byte for the whole access. The core presents one request carrying a 24-bit address, a direction, a byte-or-word size and write data. The block returns a single 16-bit read result with its byte lanes assembled, and pulses a completion flag.

The width pin picks the lane arrangement. With the pin low, the bus is 16 bits wide: even bytes travel on the second port and odd bytes on the upper port. With the pin high, the bus is 8 bits wide: every data byte travels on the second port, and a word access is cut into two byte beats, the even byte first. When the access hits internal memory, the bytes on the pins are discarded and the internal read word is returned instead. A small window of register addresses, 0x0A to 0x0D, always uses the 16-bit arrangement and is flagged as a no-wait cycle. The E strobe itself comes from an external timing generator.

Top module: `abus_steer`

## Requirements
- R1: While busy and E is high, `hi_out` carries address bits 15:8 and `mid_out` carries address bits 23:16, and both `hi_oe` and `mid_oe` are 1.
- R2: While busy, `lo_out` carries address bits 7:0 of the current beat and `lo_oe` is 1. While idle, all three output enables are 0 and all outputs are 0.
- R3: In 16-bit mode (`narrow_bus`=0) on a write with E low, the even byte (write data bits 7:0) is driven on `mid_out` and the odd byte (bits 15:8) on `hi_out`. Only the lanes the access covers are enabled: a word enables both, a byte at an even address enables only `mid_oe`, and a byte at an odd address enables only `hi_oe`.
- R4: In 8-bit mode (`narrow_bus`=1) with E low, all write data goes on `mid_out` and `hi_oe` is 0. A byte write sends write data bits 15:8 when address bit 0 is 1, and bits 7:0 when it is 0.
- R5: In 8-bit mode, a word access (`req_word`=1, even address) runs two beats. The first beat has address bit 0 = 0 and moves the even byte; the second has address bit 0 = 1 and moves the odd byte. Completion follows the second beat.
- R6: On a read, both data-port enables are 0 while E is low. The result has the even byte in bits 7:0 and the odd byte in bits 15:8, and any lane the access does not cover reads 0. A write completes with `rd_data`=0.
- R7: When `int_hit` is 1 at request time, `rd_data` is `int_rdata` masked to the covered lanes, whatever is on the pins.
- R8: Addresses 0x0A to 0x0D always use the 16-bit lane arrangement in a single beat, even when `narrow_bus`=1.
- R9: `no_wait` is 1 for the whole of an access that hits internal memory or the 0x0A to 0x0D window, and is 0 otherwise.
- R10: A beat ends on the first clock at which E is high after E was seen low. After the last beat, `done` is high for exactly one cycle with `rd_data` valid. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start an access (taken only when idle) |
| req_addr | input | 24 | Byte address of the access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_wdata | input | 16 | Write data, even byte in bits 7:0 |
| narrow_bus | input | 1 | Width pin: 1 selects the 8-bit external bus |
| int_hit | input | 1 | Access targets internal memory |
| int_rdata | input | 16 | Internal read word |
| e_strobe | input | 1 | Enable strobe: 1 = address phase, 0 = data phase |
| hi_pin_in | input | 8 | Value sampled from the upper port pins |
| mid_pin_in | input | 8 | Value sampled from the second port pins |
| lo_out | output | 8 | Low address byte port |
| lo_oe | output | 1 | Output enable of the low address port |
| hi_out | output | 8 | Upper port output value |
| hi_oe | output | 1 | Upper port output enable |
| mid_out | output | 8 | Second port output value |
| mid_oe | output | 1 | Second port output enable |
| busy | output | 1 | Access in progress |
| no_wait | output | 1 | Current access is timed as internal (no wait states) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Assembled read word |

## Verification
The assertions assume the following about the inputs. Every word request uses an even address. E is high when a request is accepted. Every beat shows at least one clock of E low before E rises again. `int_rdata` stays steady until completion. The bench raises `req` only while E is high and the block is idle, except in one directed test that pulses it while busy. All of its word vectors use even addresses. It holds E low for exactly one clock per beat, so the strobe never skips a data phase. It keeps the internal read word constant for the length of each access.

// File: rtl/abus_pkg.sv
package abus_pkg;
    localparam int LANE_W = 8;
    localparam int ADDR_W = 24;
    localparam int WORD_W = 2 * LANE_W;
    localparam int NPORT  = 2;

    // register window forced to full width and no-wait timing
    localparam logic [ADDR_W-1:0] WIN_A = 24'h00000A;
    localparam logic [ADDR_W-1:0] WIN_B = 24'h00000C;

    typedef struct packed {
        logic              active;
        logic              beat;
        logic              split;
        logic              seen_low;
        logic              wr;
        logic              word;
        logic              bus8;
        logic              inthit;
        logic              fast;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] cap;
        logic [WORD_W-1:0] rdata;
        logic              done;
    } abus_st_t;
endpackage

// File: rtl/abus_mode_dec.sv
module abus_mode_dec
    import abus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              narrow,
    input  logic              int_hit,
    output logic              bus8,
    output logic              fast
);
    logic in_win;

    always_comb begin
        in_win = (addr[ADDR_W-1:1] == WIN_A[ADDR_W-1:1]) ||
                 (addr[ADDR_W-1:1] == WIN_B[ADDR_W-1:1]);
        bus8   = narrow && !in_win;
        fast   = int_hit || in_win;
    end
endmodule

// File: rtl/abus_port_drv.sv
module abus_port_drv #(
    parameter int W = 8
) (
    input  logic         active,
    input  logic         e_high,
    input  logic [W-1:0] addr_byte,
    input  logic [W-1:0] data_byte,
    input  logic         data_en,
    output logic [W-1:0] pin_out,
    output logic         pin_oe
);
    always_comb begin
        pin_oe  = active && (e_high || data_en);
        pin_out = '0;
        if (active) begin
            if (e_high)       pin_out = addr_byte;
            else if (data_en) pin_out = data_byte;
        end
    end
endmodule

// File: rtl/abus_rd_cap.sv
module abus_rd_cap
    import abus_pkg::*;
(
    input  logic [WORD_W-1:0] cap_q,
    input  logic              bus8,
    input  logic              odd_sel,
    input  logic              lane_even,
    input  logic              lane_odd,
    input  logic [LANE_W-1:0] pin_hi,
    input  logic [LANE_W-1:0] pin_mid,
    output logic [WORD_W-1:0] cap_d
);
    always_comb begin
        cap_d = cap_q;
        if (bus8) begin
            if (odd_sel) cap_d[WORD_W-1:LANE_W] = pin_mid;
            else         cap_d[LANE_W-1:0]      = pin_mid;
        end else begin
            if (lane_even) cap_d[LANE_W-1:0]      = pin_mid;
            if (lane_odd)  cap_d[WORD_W-1:LANE_W] = pin_hi;
        end
    end
endmodule

// File: rtl/abus_steer.sv
module abus_steer
    import abus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic              req_word,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              narrow_bus,
    input  logic              int_hit,
    input  logic [WORD_W-1:0] int_rdata,
    input  logic              e_strobe,
    input  logic [LANE_W-1:0] hi_pin_in,
    input  logic [LANE_W-1:0] mid_pin_in,
    output logic [LANE_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [LANE_W-1:0] hi_out,
    output logic              hi_oe,
    output logic [LANE_W-1:0] mid_out,
    output logic              mid_oe,
    output logic              busy,
    output logic              no_wait,
    output logic              done,
    output logic [WORD_W-1:0] rd_data
);
    abus_st_t q, d;

    logic              req_bus8, req_fast;
    logic              odd_sel, lane_even, lane_odd;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] cap_next, lane_mask;
    logic [LANE_W-1:0] mid_data;
    logic              mid_en, hi_en;
    logic [LANE_W-1:0] p_data [NPORT];
    logic              p_en   [NPORT];
    logic [LANE_W-1:0] p_out  [NPORT];
    logic              p_oe   [NPORT];

    // observation points for the bound checker
    logic st_wr, st_bus8, st_beat, st_word;

    abus_mode_dec u_dec (
        .addr    (req_addr),
        .narrow  (narrow_bus),
        .int_hit (int_hit),
        .bus8    (req_bus8),
        .fast    (req_fast)
    );

    always_comb begin
        odd_sel   = q.word ? q.beat : q.addr[0];
        lane_even = q.word || !q.addr[0];
        lane_odd  = q.word ||  q.addr[0];
        cur_addr  = {q.addr[ADDR_W-1:1], q.addr[0] | q.beat};
        mid_data  = (q.bus8 && odd_sel) ? q.wdata[WORD_W-1:LANE_W]
                                        : q.wdata[LANE_W-1:0];
        mid_en    = q.wr && (q.bus8 || lane_even);
        hi_en     = q.wr && !q.bus8 && lane_odd;
        lane_mask = {{LANE_W{lane_odd}}, {LANE_W{lane_even}}};
        // port 0 = upper group, port 1 = second group
        p_data[0] = q.wdata[WORD_W-1:LANE_W];
        p_en[0]   = hi_en;
        p_data[1] = mid_data;
        p_en[1]   = mid_en;
    end

    abus_rd_cap u_cap (
        .cap_q     (q.cap),
        .bus8      (q.bus8),
        .odd_sel   (odd_sel),
        .lane_even (lane_even),
        .lane_odd  (lane_odd),
        .pin_hi    (hi_pin_in),
        .pin_mid   (mid_pin_in),
        .cap_d     (cap_next)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        abus_port_drv #(.W(LANE_W)) u_drv (
            .active    (q.active),
            .e_high    (e_strobe),
            .addr_byte (cur_addr[(g+1)*LANE_W +: LANE_W]),
            .data_byte (p_data[g]),
            .data_en   (p_en[g]),
            .pin_out   (p_out[g]),
            .pin_oe    (p_oe[g])
        );
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (req) begin
                d.active   = 1'b1;
                d.beat     = 1'b0;
                d.seen_low = 1'b0;
                d.wr       = req_wr;
                d.word     = req_word;
                d.bus8     = req_bus8;
                d.split    = req_bus8 && req_word;
                d.inthit   = int_hit;
                d.fast     = req_fast;
                d.addr     = req_addr;
                d.wdata    = req_wdata;
                d.cap      = '0;
            end
        end else if (!e_strobe) begin
            d.seen_low = 1'b1;
            d.cap      = cap_next;
        end else if (q.seen_low) begin
            d.seen_low = 1'b0;
            if (q.split && !q.beat) begin
                d.beat = 1'b1;
            end else begin
                d.active = 1'b0;
                d.done   = 1'b1;
                if (q.wr)          d.rdata = '0;
                else if (q.inthit) d.rdata = int_rdata & lane_mask;
                else               d.rdata = q.cap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        lo_out  = q.active ? cur_addr[LANE_W-1:0] : '0;
        lo_oe   = q.active;
        hi_out  = p_out[0];
        hi_oe   = p_oe[0];
        mid_out = p_out[1];
        mid_oe  = p_oe[1];
        busy    = q.active;
        no_wait = q.active && q.fast;
        done    = q.done;
        rd_data = q.rdata;
        st_wr   = q.wr;
        st_bus8 = q.bus8;
        st_beat = q.beat;
        st_word = q.word;
    end
endmodule

// File: rtl/abus_steer_chk.sv
module abus_steer_chk
    import abus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              e_strobe,
    input logic [LANE_W-1:0] lo_out,
    input logic              lo_oe,
    input logic              hi_oe,
    input logic              mid_oe,
    input logic              no_wait,
    input logic              done,
    input logic              st_wr,
    input logic              st_bus8,
    input logic              st_beat,
    input logic              st_word
);
    p_addr_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy && e_strobe |-> hi_oe && mid_oe);

    p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && $stable(st_beat) |-> $stable(lo_out));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !lo_oe && !hi_oe && !mid_oe);

    p_narrow_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !e_strobe && st_bus8 |-> !hi_oe);

    p_even_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && st_word && !st_beat |-> !lo_out[0]);

    p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !e_strobe && !st_wr |-> !hi_oe && !mid_oe);

    p_nowait_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(no_wait));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

bind abus_steer abus_steer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .e_strobe (e_strobe),
    .lo_out   (lo_out),
    .lo_oe    (lo_oe),
    .hi_oe    (hi_oe),
    .mid_oe   (mid_oe),
    .no_wait  (no_wait),
    .done     (done),
    .st_wr    (st_wr),
    .st_bus8  (st_bus8),
    .st_beat  (st_beat),
    .st_word  (st_word)
);

// File: tb/abus_steer_bench.sv
module abus_steer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        narrow_bus = 1'b0;
    logic        int_hit = 1'b0;
    logic [15:0] int_rdata = '0;
    logic        e_strobe = 1'b1;
    logic [7:0]  hi_pin_in = '0;
    logic [7:0]  mid_pin_in = '0;
    logic [7:0]  lo_out, hi_out, mid_out;
    logic        lo_oe, hi_oe, mid_oe, busy, no_wait, done;
    logic [15:0] rd_data;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    abus_steer u_abus_steer (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .req_wr(req_wr), .req_word(req_word), .req_wdata(req_wdata),
        .narrow_bus(narrow_bus), .int_hit(int_hit), .int_rdata(int_rdata),
        .e_strobe(e_strobe), .hi_pin_in(hi_pin_in), .mid_pin_in(mid_pin_in),
        .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe),
        .mid_out(mid_out), .mid_oe(mid_oe), .busy(busy), .no_wait(no_wait),
        .done(done), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        wr;
        logic        word;
        logic        narrow;
        logic        inth;
        logic [23:0] addr;
        logic [15:0] wdata;
        logic [7:0]  pin_hi;
        logic [7:0]  mid0;
        logic [7:0]  mid1;
        logic [15:0] int_rd;
        logic [1:0]  beats;
        logic [7:0]  em0;
        logic        emo0;
        logic [7:0]  eh0;
        logic        eho0;
        logic [7:0]  em1;
        logic        nowait;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1,1,0,0,24'h123456,16'hBEEF,8'h00,8'h00,8'h00,16'h0000,2'd1,8'hEF,1,8'hBE,1,8'h00,0,16'h0000},
        '{1,0,0,0,24'h00A001,16'h5A3C,8'h00,8'h00,8'h00,16'h0000,2'd1,8'h00,0,8'h5A,1,8'h00,0,16'h0000},
        '{1,0,1,0,24'h400010,16'h77C4,8'h00,8'h00,8'h00,16'h0000,2'd1,8'hC4,1,8'h00,0,8'h00,0,16'h0000},
        '{1,1,1,0,24'h200020,16'h1289,8'h00,8'h00,8'h00,16'h0000,2'd2,8'h89,1,8'h00,0,8'h12,0,16'h0000},
        '{0,1,0,0,24'h010100,16'h0000,8'hA5,8'h3E,8'h00,16'h0000,2'd1,8'h00,0,8'h00,0,8'h00,0,16'hA53E},
        '{0,0,0,0,24'h010101,16'h0000,8'h9D,8'h44,8'h00,16'h0000,2'd1,8'h00,0,8'h00,0,8'h00,0,16'h9D00},
        '{0,1,1,0,24'h030300,16'h0000,8'hEE,8'h61,8'hF2,16'h0000,2'd2,8'h00,0,8'h00,0,8'h00,0,16'hF261},
        '{0,1,0,1,24'h050500,16'h0000,8'h11,8'h22,8'h00,16'hCAFE,2'd1,8'h00,0,8'h00,0,8'h00,1,16'hCAFE},
        '{0,0,1,1,24'h000104,16'h0000,8'h00,8'h33,8'h00,16'hCAFE,2'd1,8'h00,0,8'h00,0,8'h00,1,16'h00FE},
        '{0,1,1,0,24'h00000A,16'h0000,8'h5B,8'h6C,8'h00,16'h0000,2'd1,8'h00,0,8'h00,0,8'h00,1,16'h5B6C},
        '{1,1,1,0,24'h00000C,16'h0F0E,8'h00,8'h00,8'h00,16'h0000,2'd1,8'h0E,1,8'h0F,1,8'h00,1,16'h0000},
        '{0,0,1,0,24'h000035,16'h0000,8'hEE,8'h8B,8'h00,16'h0000,2'd1,8'h00,0,8'h00,0,8'h00,0,16'h8B00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R2 reset lo_oe", lo_oe, 0);
        chk("R2 reset hi_oe", hi_oe, 0);
        chk("R2 reset mid_oe", mid_oe, 0);
        chk("R10 reset done", done, 0);
        chk("R10 reset busy", busy, 0);
        chk("R6 reset rd_data", rd_data, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            @(negedge clk);
            req = 1'b1; req_addr = v.addr; req_wr = v.wr; req_word = v.word;
            req_wdata = v.wdata; narrow_bus = v.narrow; int_hit = v.inth;
            int_rdata = v.int_rd; e_strobe = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk("R1 hi addr", hi_out, v.addr[15:8]);
            chk("R1 mid addr", mid_out, v.addr[23:16]);
            chk("R1 oe", {hi_oe, mid_oe}, 2'b11);
            chk("R2 lo addr", lo_out, v.addr[7:0]);
            chk("R2 lo_oe", lo_oe, 1);
            chk("R9 no_wait", no_wait, v.nowait);
            for (int b = 0; b < 2; b++) begin
                e_strobe = 1'b0;
                hi_pin_in = v.pin_hi;
                mid_pin_in = (b == 0) ? v.mid0 : v.mid1;
                #1;
                if (b == 0) begin
                    chk("R3 R4 R6 mid data", mid_out, v.em0);
                    chk("R3 R4 R6 mid_oe", mid_oe, v.emo0);
                    chk("R3 R4 R6 hi data", hi_out, v.eh0);
                    chk("R3 R4 R6 hi_oe", hi_oe, v.eho0);
                end else begin
                    chk("R5 second beat mid", mid_out, v.em1);
                    chk("R5 second beat mid_oe", mid_oe, v.wr);
                    chk("R5 R4 second beat hi_oe", hi_oe, 0);
                end
                @(negedge clk);
                e_strobe = 1'b1;
                @(negedge clk);
                if (b == int'(v.beats) - 1) begin
                    chk("R10 done", done, 1);
                    chk("R6 R7 R8 rd_data", rd_data, v.exp_rd);
                    chk("R10 idle after", busy, 0);
                    break;
                end else begin
                    chk("R5 no early done", done, 0);
                    chk("R5 odd beat addr", lo_out, {v.addr[7:1], 1'b1});
                    chk("R9 no_wait beat2", no_wait, v.nowait);
                end
            end
            @(negedge clk);
            chk("R10 done single", done, 0);
            chk("R2 idle oe", {lo_oe, hi_oe, mid_oe}, 3'b000);
        end

        // request while busy is ignored
        @(negedge clk);
        req = 1'b1; req_addr = 24'h0A0B40; req_wr = 1'b0; req_word = 1'b1;
        narrow_bus = 1'b0; int_hit = 1'b0; e_strobe = 1'b1;
        @(negedge clk);
        req_addr = 24'h777777; req_word = 1'b0; narrow_bus = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R10 busy req ignored lo", lo_out, 8'h40);
        chk("R10 busy req ignored hi", hi_out, 8'h0B);
        e_strobe = 1'b0; hi_pin_in = 8'hD1; mid_pin_in = 8'hC2;
        #1;
        chk("R6 read float", {hi_oe, mid_oe}, 2'b00);
        @(negedge clk);
        e_strobe = 1'b1;
        @(negedge clk);
        chk("R10 first request completes", done, 1);
        chk("R6 word read", rd_data, 16'hD1C2);

        // idle strobe toggling drives nothing
        @(negedge clk);
        e_strobe = 1'b0;
        #1;
        chk("R2 idle E low oe", {lo_oe, hi_oe, mid_oe}, 3'b000);
        chk("R9 idle no_wait", no_wait, 0);
        @(negedge clk);
        e_strobe = 1'b1;
        @(negedge clk);
        chk("R10 idle no done", done, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule